// File: doc/BRIEF.md
# Superframe CRC-12 Checker

This block protects the maintenance channel of a received line superframe with a 12-bit cyclic redundancy check. While a superframe is arriving, every qualified data bit is folded into a running CRC. When the next superframe start strobe arrives, the finished value is frozen and kept for one more superframe. During that next superframe the received check bits arrive one at a time on their own strobe. At the following superframe start the frozen value is compared with the collected bits, and a registered error flag is updated.

The frozen value is also driven out as a parallel word. A transmit framer can place it in the check-bit positions of its next outgoing superframe. Maintenance bits other than the check bits are not touched here; they travel on a separate path. A level input from the framing logic reports superframe sync. The check restarts its warm-up whenever sync is regained, so that no partial superframe can raise a false error.

Top module: `crc12_sf_check`

## Requirements
- R1: While reset is high, and in the first cycle after it, `crc_err` is 0 and `tx_crc_word` is all ones (12'hFFF).
- R2: The CRC uses the generator x^12+x^11+x^3+x^2+x+1, processes bits in arrival order with no final inversion, and is preset to all ones at every superframe start. Only cycles with `bit_vld` high contribute. From the cycle after a strobe until the cycle after the next strobe, `tx_crc_word` holds the CRC of the superframe that the first strobe closed.
- R3: A data bit that is valid in the same cycle as `sf_start` is the first bit of the new superframe.
- R4: Received check bits arrive most significant bit first on `rcrc_bit` when `rcrc_vld` is high. At the next strobe they are compared with the frozen CRC of the previous superframe. From the cycle after that strobe, `crc_err` is 1 on a mismatch and 0 on a match.
- R5: If the number of check bits received in a superframe is not exactly 12, the compare at the next strobe sets `crc_err` to 1, whatever the values of the bits.
- R6: After reset, and after `in_sync` rises, the first two strobes perform no compare. The first compare happens at the third strobe.
- R7: While `in_sync` is low, `crc_err` is forced to 0 from the following cycle, and the warm-up of R6 restarts.
- R8: `crc_err` changes only in the cycle after a strobe, or after a cycle with `in_sync` low. `tx_crc_word` changes only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sync | input | 1 | Superframe sync indication from the framer |
| sf_start | input | 1 | One-cycle strobe marking the first cycle of a superframe |
| bit_vld | input | 1 | Qualifier for `bit_in` |
| bit_in | input | 1 | Protected data bit |
| rcrc_vld | input | 1 | Qualifier for `rcrc_bit` |
| rcrc_bit | input | 1 | Received check bit, most significant bit first |
| crc_err | output | 1 | Registered check result, updated once per superframe |
| tx_crc_word | output | 12 | CRC of the last completed superframe, for transmit insertion |

## Verification
A wrong running-CRC state stays hidden until the strobe that closes the superframe. It then shows at once as a wrong `tx_crc_word`, and one superframe later as a wrong `crc_err`. Faults in the check-bit collector or its bit count show only at a compare strobe. Faults in the warm-up counter show at the second strobe after reset or sync, where deliberately corrupted check bits are supplied. Because the reference model is compared on every clock, a flag that moves between strobes is reported in the cycle it moves.

// File: rtl/crc12_pkg.sv
package crc12_pkg;

  localparam int DEF_CRC_W  = 12;
  localparam logic [DEF_CRC_W-1:0] DEF_POLY   = 12'h80F;
  localparam logic [DEF_CRC_W-1:0] DEF_PRESET = 12'hFFF;
  localparam int DEF_ARM_SF = 2;

  typedef enum logic {
    ORDER_MSB_FIRST = 1'b0,
    ORDER_LSB_FIRST = 1'b1
  } bit_order_e;

endpackage

// File: rtl/crc12_lfsr.sv
module crc12_lfsr #(
  parameter int CRC_W = 12,
  parameter logic [CRC_W-1:0] POLY   = 12'h80F,
  parameter logic [CRC_W-1:0] PRESET = 12'hFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sf_start,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic [CRC_W-1:0] held_crc
);

  logic [CRC_W-1:0] run_q;
  logic [CRC_W-1:0] base;
  logic [CRC_W-1:0] stepped;
  logic             fb;

  // A strobe restarts the superframe; a bit in that cycle steps from the preset.
  assign base = sf_start ? PRESET : run_q;
  assign fb   = base[CRC_W-1] ^ bit_in;

  genvar gi;
  generate
    for (gi = 0; gi < CRC_W; gi++) begin : g_tap
      if (gi == 0) begin : g_low
        assign stepped[gi] = POLY[gi] & fb;
      end else begin : g_up
        assign stepped[gi] = base[gi-1] ^ (POLY[gi] & fb);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= PRESET;
      held_crc <= PRESET;
    end else begin
      run_q <= bit_vld ? stepped : base;
      if (sf_start) begin
        held_crc <= run_q;
      end
    end
  end

endmodule

// File: rtl/crc12_rx_collect.sv
module crc12_rx_collect
  import crc12_pkg::*;
#(
  parameter int CRC_W = 12,
  parameter bit_order_e ORDER = ORDER_MSB_FIRST,
  localparam int CNT_W = $clog2(CRC_W + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sf_start,
  input  logic             rx_vld,
  input  logic             rx_bit,
  output logic [CRC_W-1:0] rx_word,
  output logic [CNT_W-1:0] rx_cnt
);

  localparam logic [CNT_W-1:0] SAT = CNT_W'(CRC_W + 1);

  logic [CRC_W-1:0] word_base;
  logic [CNT_W-1:0] cnt_base;
  logic [CRC_W-1:0] word_shift;

  assign word_base = sf_start ? '0 : rx_word;
  assign cnt_base  = sf_start ? '0 : rx_cnt;

  generate
    if (ORDER == ORDER_MSB_FIRST) begin : g_msb
      assign word_shift = {word_base[CRC_W-2:0], rx_bit};
    end else begin : g_lsb
      assign word_shift = {rx_bit, word_base[CRC_W-1:1]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word <= '0;
      rx_cnt  <= '0;
    end else begin
      rx_word <= rx_vld ? word_shift : word_base;
      if (rx_vld && (cnt_base != SAT)) begin
        rx_cnt <= cnt_base + CNT_W'(1);
      end else begin
        rx_cnt <= cnt_base;
      end
    end
  end

endmodule

// File: rtl/crc12_arm.sv
module crc12_arm #(
  parameter int ARM_SF = 2,
  localparam int AW = $clog2(ARM_SF + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic in_sync,
  input  logic sf_start,
  output logic cmp_en
);

  localparam logic [AW-1:0] LAST = AW'(ARM_SF);

  logic [AW-1:0] seen_q;

  assign cmp_en = in_sync && sf_start && (seen_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !in_sync) begin
      seen_q <= '0;
    end else if (sf_start && (seen_q != LAST)) begin
      seen_q <= seen_q + AW'(1);
    end
  end

endmodule

// File: rtl/crc12_sf_check.sv
module crc12_sf_check
  import crc12_pkg::*;
#(
  parameter int CRC_W = DEF_CRC_W,
  parameter logic [CRC_W-1:0] POLY   = DEF_POLY,
  parameter logic [CRC_W-1:0] PRESET = DEF_PRESET,
  parameter int ARM_SF = DEF_ARM_SF,
  parameter bit_order_e ORDER = ORDER_MSB_FIRST
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_sync,
  input  logic             sf_start,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             rcrc_vld,
  input  logic             rcrc_bit,
  output logic             crc_err,
  output logic [CRC_W-1:0] tx_crc_word
);

  localparam int CNT_W = $clog2(CRC_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CRC_W);

  logic [CRC_W-1:0] held_crc;
  logic [CRC_W-1:0] rx_word;
  logic [CNT_W-1:0] rx_cnt;
  logic             cmp_en;

  crc12_lfsr #(
    .CRC_W  (CRC_W),
    .POLY   (POLY),
    .PRESET (PRESET)
  ) u_lfsr (
    .clk      (clk),
    .rst      (rst),
    .sf_start (sf_start),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .held_crc (held_crc)
  );

  crc12_rx_collect #(
    .CRC_W (CRC_W),
    .ORDER (ORDER)
  ) u_rx (
    .clk      (clk),
    .rst      (rst),
    .sf_start (sf_start),
    .rx_vld   (rcrc_vld),
    .rx_bit   (rcrc_bit),
    .rx_word  (rx_word),
    .rx_cnt   (rx_cnt)
  );

  crc12_arm #(
    .ARM_SF (ARM_SF)
  ) u_arm (
    .clk      (clk),
    .rst      (rst),
    .in_sync  (in_sync),
    .sf_start (sf_start),
    .cmp_en   (cmp_en)
  );

  always_ff @(posedge clk) begin
    if (rst || !in_sync) begin
      crc_err <= 1'b0;
    end else if (cmp_en) begin
      crc_err <= (rx_word != held_crc) || (rx_cnt != FULL);
    end
  end

  assign tx_crc_word = held_crc;

endmodule

// File: rtl/crc12_sf_check_sva.sv
module crc12_sf_check_sva #(
  parameter int CRC_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             in_sync,
  input logic             sf_start,
  input logic             crc_err,
  input logic [CRC_W-1:0] tx_crc_word
);

  logic [1:0] strobes_q;

  always_ff @(posedge clk) begin
    if (rst || !in_sync) begin
      strobes_q <= 2'd0;
    end else if (sf_start && (strobes_q != 2'd3)) begin
      strobes_q <= strobes_q + 2'd1;
    end
  end

  AST_RESET_TX_ONES: assert property (@(posedge clk)
    $past(rst) |-> (tx_crc_word == {CRC_W{1'b1}}) && !crc_err); // R1

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(sf_start) |-> $stable(tx_crc_word)); // R2

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(in_sync) && !$past(sf_start)) |-> $stable(crc_err)); // R8

  AST_UNSYNC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !$past(in_sync) |-> !crc_err); // R7

  AST_NO_EARLY_ERR: assert property (@(posedge clk) disable iff (rst)
    crc_err |-> (strobes_q == 2'd3)); // R6

endmodule

bind crc12_sf_check crc12_sf_check_sva #(
  .CRC_W (CRC_W)
) u_sva (
  .clk         (clk),
  .rst         (rst),
  .in_sync     (in_sync),
  .sf_start    (sf_start),
  .crc_err     (crc_err),
  .tx_crc_word (tx_crc_word)
);

// File: tb/sim_crc12_sf_check.sv
`timescale 1ns/1ps
module sim_crc12_sf_check;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_sync = 1'b1;
  logic        sf_start = 1'b0;
  logic        bit_vld = 1'b0;
  logic        bit_in = 1'b0;
  logic        rcrc_vld = 1'b0;
  logic        rcrc_bit = 1'b0;
  logic        crc_err;
  logic [11:0] tx_crc_word;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  crc12_sf_check u0 (
    .clk (clk), .rst (rst), .in_sync (in_sync), .sf_start (sf_start),
    .bit_vld (bit_vld), .bit_in (bit_in), .rcrc_vld (rcrc_vld),
    .rcrc_bit (rcrc_bit), .crc_err (crc_err), .tx_crc_word (tx_crc_word)
  );

  // reference model state
  bit        m_data[$];
  bit        m_rx[$];
  bit [11:0] m_held = 12'hFFF;
  bit        m_err = 1'b0;
  int        m_seen = 0;
  bit [11:0] last_sf_crc;

  function automatic bit [11:0] crc_of(input bit q[$]);
    bit [11:0] c = 12'hFFF;
    foreach (q[i]) begin
      bit f = c[11] ^ q[i];
      c = {c[10:0], 1'b0};
      if (f) c = c ^ 12'h80F;
    end
    return c;
  endfunction

  function automatic bit [11:0] fold(input bit q[$]);
    bit [11:0] v = 12'h000;
    foreach (q[i]) v = {v[10:0], q[i]};
    return v;
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      m_data = {}; m_rx = {}; m_held = 12'hFFF; m_err = 1'b0; m_seen = 0;
    end else begin
      if (!in_sync) m_err = 1'b0;
      else if (sf_start && m_seen == 2)
        m_err = (fold(m_rx) != m_held) || (m_rx.size() != 12);
      if (!in_sync) m_seen = 0;
      else if (sf_start && m_seen < 2) m_seen++;
      if (sf_start) begin
        m_held = crc_of(m_data);
        m_data = {};
        m_rx = {};
      end
      if (bit_vld) m_data.push_back(bit_in);
      if (rcrc_vld) m_rx.push_back(rcrc_bit);
    end
  endtask

  task automatic tick(input bit s, input bit dv, input bit db, input bit rv, input bit rb);
    sf_start = s; bit_vld = dv; bit_in = db; rcrc_vld = rv; rcrc_bit = rb;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R4 flag vs model", {11'd0, crc_err}, {11'd0, m_err});
    chk("R2 tx word vs model", tx_crc_word, m_held);
  endtask

  // one superframe: strobe cycle, then n cycles carrying data and check bits
  task automatic send_sf(input int seed, input bit [11:0] rword, input int rcnt, input bit bit_on_strobe);
    bit sent[$];
    int r = 0;
    bit b0 = ((seed * 5) >> 1) & 1;
    tick(1'b1, bit_on_strobe, b0, 1'b0, 1'b0);
    if (bit_on_strobe) sent.push_back(b0);
    for (int i = 0; i < 40; i++) begin
      bit dv = (i % 4) != 3;
      bit db = (((seed * 37 + i * 11) >> 2) & 1) != 0;
      bit rv = (r < rcnt) && ((i % 3) != 1);
      bit rb = (r < 12) ? rword[11 - r] : 1'b1;
      tick(1'b0, dv, db, rv, rb);
      if (dv) sent.push_back(db);
      if (rv) r++;
    end
    last_sf_crc = crc_of(sent);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [11:0] crc_a, crc_b, p;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); model_edge(); @(negedge clk);
    end
    chk("R1 reset flag", {11'd0, crc_err}, 12'd0);
    chk("R1 reset tx word", tx_crc_word, 12'hFFF);
    rst = 1'b0;
    tick(0, 0, 0, 0, 0);
    chk("R1 first cycle after reset", tx_crc_word, 12'hFFF);

    send_sf(1, 12'hABC, 12, 1'b0);            // first superframe, garbage check bits
    crc_a = last_sf_crc;
    chk("R6 no compare on first strobe", {11'd0, crc_err}, 12'd0);
    send_sf(2, crc_a, 12, 1'b1);              // strobe 2 closes A, no compare
    crc_b = last_sf_crc;
    chk("R2 tx word is CRC of closed superframe", tx_crc_word, crc_a);
    chk("R6 no compare on second strobe", {11'd0, crc_err}, 12'd0);
    send_sf(3, crc_b ^ 12'h001, 12, 1'b0);    // strobe 3 compares A: match
    chk("R3 strobe-cycle bit counted", tx_crc_word, crc_b);
    chk("R4 match clears flag", {11'd0, crc_err}, 12'd0);
    p = last_sf_crc;
    send_sf(4, p, 12, 1'b0);                  // compares B vs corrupted
    chk("R4 mismatch sets flag", {11'd0, crc_err}, 12'd1);
    p = last_sf_crc;
    send_sf(5, p, 11, 1'b1);                  // compares C: match
    chk("R4 match after mismatch", {11'd0, crc_err}, 12'd0);
    p = last_sf_crc;
    send_sf(6, p, 12, 1'b0);                  // compares D with 11 bits
    chk("R5 short count flags", {11'd0, crc_err}, 12'd1);
    p = last_sf_crc;
    send_sf(7, p, 13, 1'b0);                  // compares E: match
    chk("R4 match with full count", {11'd0, crc_err}, 12'd0);
    p = last_sf_crc;
    send_sf(8, p, 12, 1'b0);                  // compares F with 13 bits
    chk("R5 long count flags", {11'd0, crc_err}, 12'd1);

    in_sync = 1'b0;
    tick(0, 1, 1, 0, 0);
    chk("R7 sync loss clears flag", {11'd0, crc_err}, 12'd0);
    tick(1, 1, 0, 1, 1);
    in_sync = 1'b1;
    send_sf(9, 12'h5A5, 12, 1'b0);            // strobe 1 after sync
    p = last_sf_crc;
    send_sf(10, p, 12, 1'b0);                 // strobe 2: garbage must not compare
    chk("R6 warm-up after sync", {11'd0, crc_err}, 12'd0);
    p = last_sf_crc;
    send_sf(11, p, 12, 1'b1);                 // strobe 3: compares S9 vs its CRC
    chk("R4 match after resync", {11'd0, crc_err}, 12'd0);
    tick(1, 0, 0, 0, 0);
    chk("R2 tx word after closing strobe", tx_crc_word, last_sf_crc);
    for (int i = 0; i < 4; i++) tick(0, 0, 0, 0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule